// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block sits between a synchronous host port and an asynchronous 128K x 8 DRAM that takes its address in two halves over nine shared pins. A host places a 17-bit byte address, a read/write flag and write data on the port under a valid/ready handshake. The block drives the row strobe, column strobe, write strobe, output-enable strobe and the shared address pins, then returns read data with a one-cycle valid pulse.

Once a row has been opened it stays open. A later access to the same row needs only a column-strobe cycle. An access to a different row first closes the open row, waits out the precharge and then opens the new one. The block also closes the row by itself before the row strobe has been low for too long. Every minimum strobe spacing is a whole number of clock cycles held in a parameter, so other speed grades only need new counts. The defaults suit a 100 MHz clock.

A refresh engine asks for the strobes with a request line. The block closes any open row, waits out the precharge, then raises a grant. While the grant is high, all of its own strobes stay inactive and no host request is taken.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four strobes are high, the data driver is off, rsp_valid and ref_gnt are low, and req_ready is high.
- R2: When the row strobe falls, the pins carry the row, which is host address bits 16:8, on pins 8:0. When the column strobe falls, the pins carry the column, which is host address bits 7:0, on pins 7:0, and pin 8 is 0.
- R3: The row address stays on the pins for at least one cycle after the row strobe falls. The column address stays unchanged for as long as the column strobe is low.
- R4: The row strobe stays low for at least T_RAS cycles (default 4). Before it falls again it stays high for at least T_RP cycles (default 3).
- R5: The column strobe falls only while the row strobe is low, and at least T_RCD cycles (default 2) after the row strobe fell. It stays low for at least T_CAS cycles (default 2).
- R6: A request to the open row causes no row-strobe edge. Successive column-strobe falls in one row are at least T_PC cycles (default 3) apart.
- R7: A request to any other row causes exactly one row-strobe fall, and that fall carries the new row.
- R8: A read holds output-enable low and the write strobe high while the column strobe is low. The byte sampled from the DRAM data input on the edge that raises the column strobe appears on rsp_rdata, with rsp_valid high for exactly one cycle.
- R9: A write holds the write strobe low, output-enable high and the data driver on with the host byte for as long as the column strobe is low. A write produces no rsp_valid.
- R10: The row strobe is never low for more than T_RAS_MAX cycles (default 7500). An idle open row is closed within 20 cycles of that limit.
- R11: While ref_req is high, the open row is closed, and after T_RP cycles of precharge ref_gnt rises. While ref_gnt is high, both strobes stay high and req_ready is low. Once ref_req falls, ref_gnt falls and the next access opens its row afresh.
- R12: Each accepted handshake causes exactly one column-strobe cycle. A request held valid while req_ready is low causes no strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 17 | Byte address: row in 16:8, column in 7:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 8 | Read byte |
| ref_req | input | 1 | Refresh engine asks for the strobes |
| ref_gnt | output | 1 | Strobes released to the refresh engine |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Shared row/column address pins |
| dram_dq_out | output | 8 | Byte driven toward the DRAM |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 8 | Byte returned by the DRAM |

## Verification
The bench alternates page hits and row misses, including row 511, column 255 and column 0, so that a design which reopens the row on every access, or which skips the close on a miss, shows the wrong count of row-strobe falls or returns bytes from the wrong row. It holds a request valid during a refresh grant to catch a controller that ignores the grant and slips in a column cycle. It leaves a row idle past the row-strobe limit, so a missing or early close shows up in the measured low time. It also measures every strobe spacing in cycles, which exposes any off-by-one in the precharge, row-to-column or column-width counters.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 8,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CAC     = 2,
  parameter int T_CAA     = 2,
  parameter int T_PC      = 3,
  parameter int T_RAS_MAX = 7500
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic                    req_we,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic                    ref_req,
  output logic                    ref_gnt,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [ROW_W-1:0]        dram_addr,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);

  localparam int AW    = ROW_W + COL_W;
  localparam int T_RD0 = (T_CAC > T_CAA) ? T_CAC : T_CAA;
  localparam int T_RD  = (T_CAS > T_RD0) ? T_CAS : T_RD0;
  localparam int T_CP  = (T_PC - T_CAS > 1) ? T_PC - T_CAS : 1;
  localparam int LIMIT = T_RAS_MAX - T_RD - T_CP - 3;
  localparam int CW    = $clog2(T_RAS_MAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_CAS, S_CLOSE, S_ACT, S_REF} state_t;

  state_t            state;
  logic [CW-1:0]     tcnt, ras_lo, ras_hi, cas_hi;
  logic              row_open, pend;
  logic [ROW_W-1:0]  open_row;
  logic [AW-1:0]     p_addr;
  logic              p_we;
  logic [DATA_W-1:0] p_wdata;

  logic hit, expire, pre_ok, cp_ok, fire, c_we;
  logic [COL_W-1:0]  c_col;
  logic [DATA_W-1:0] c_wdata;
  logic [CW-1:0]     cas_len;

  assign hit     = row_open && (req_addr[AW-1:COL_W] == open_row);
  assign expire  = row_open && (ras_lo >= CW'(LIMIT));
  assign pre_ok  = ras_hi >= CW'(T_RP);
  assign cp_ok   = cas_hi >= CW'(T_CP);
  assign req_ready = (state == S_IDLE) && !ref_req && !expire && (row_open ? cp_ok : pre_ok);
  assign fire    = req_valid && req_ready;
  assign c_we    = (state == S_IDLE) ? req_we : p_we;
  assign c_col   = (state == S_IDLE) ? req_addr[COL_W-1:0] : p_addr[COL_W-1:0];
  assign c_wdata = (state == S_IDLE) ? req_wdata : p_wdata;
  assign cas_len = p_we ? CW'(T_CAS) : CW'(T_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo <= '0;
      ras_hi <= CW'(T_RP);
      cas_hi <= CW'(T_CP);
    end else begin
      ras_lo <= dram_ras_n ? CW'(1) : ((ras_lo == CW'(T_RAS_MAX + 1)) ? ras_lo : ras_lo + 1'b1);
      ras_hi <= (!dram_ras_n || ref_gnt) ? CW'(1) : (pre_ok ? ras_hi : ras_hi + 1'b1);
      cas_hi <= !dram_cas_n ? CW'(1) : (cp_ok ? cas_hi : cas_hi + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tcnt        <= CW'(1);
      row_open    <= 1'b0;
      pend        <= 1'b0;
      open_row    <= '0;
      p_addr      <= '0;
      p_we        <= 1'b0;
      p_wdata     <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      ref_gnt     <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (fire) begin
            p_addr  <= req_addr;
            p_we    <= req_we;
            p_wdata <= req_wdata;
            if (hit) begin
              dram_cas_n  <= 1'b0;
              dram_addr   <= {{(ROW_W-COL_W){1'b0}}, c_col};
              dram_we_n   <= !c_we;
              dram_oe_n   <= c_we;
              dram_dq_oe  <= c_we;
              dram_dq_out <= c_wdata;
              tcnt        <= CW'(1);
              state       <= S_CAS;
            end else if (row_open) begin
              pend  <= 1'b1;
              state <= S_CLOSE;
            end else begin
              dram_ras_n <= 1'b0;
              dram_addr  <= req_addr[AW-1:COL_W];
              row_open   <= 1'b1;
              open_row   <= req_addr[AW-1:COL_W];
              tcnt       <= CW'(1);
              state      <= S_RCD;
            end
          end else if (row_open && (ref_req || expire) && cp_ok) begin
            pend  <= 1'b0;
            state <= S_CLOSE;
          end else if (!row_open && ref_req && pre_ok) begin
            ref_gnt <= 1'b1;
            state   <= S_REF;
          end
        end
        S_RCD: begin
          if (tcnt >= CW'(T_RCD)) begin
            dram_cas_n  <= 1'b0;
            dram_addr   <= {{(ROW_W-COL_W){1'b0}}, c_col};
            dram_we_n   <= !c_we;
            dram_oe_n   <= c_we;
            dram_dq_oe  <= c_we;
            dram_dq_out <= c_wdata;
            tcnt        <= CW'(1);
            state       <= S_CAS;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_CAS: begin
          if (tcnt >= cas_len) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!p_we) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
            state <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_CLOSE: begin
          if (ras_lo >= CW'(T_RAS)) begin
            dram_ras_n <= 1'b1;
            row_open   <= 1'b0;
            state      <= pend ? S_ACT : S_IDLE;
          end
        end
        S_ACT: begin
          if (pre_ok) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= p_addr[AW-1:COL_W];
            row_open   <= 1'b1;
            open_row   <= p_addr[AW-1:COL_W];
            pend       <= 1'b0;
            tcnt       <= CW'(1);
            state      <= S_RCD;
          end
        end
        S_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int ROW_W     = 9,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RAS_MAX = 7500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n,
  input logic             dram_dq_oe,
  input logic [ROW_W-1:0] dram_addr,
  input logic             rsp_valid,
  input logic             ref_gnt,
  input logic             req_ready
);

  localparam int CW = $clog2(T_RAS_MAX + 2);

  logic [CW-1:0] lo_c, hi_c, clo_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_c  <= '0;
      hi_c  <= CW'(T_RP);
      clo_c <= '0;
    end else begin
      lo_c  <= dram_ras_n ? '0 : ((lo_c == CW'(T_RAS_MAX + 1)) ? lo_c : lo_c + 1'b1);
      hi_c  <= !dram_ras_n ? '0 : ((hi_c >= CW'(T_RP)) ? hi_c : hi_c + 1'b1);
      clo_c <= dram_cas_n ? '0 : ((clo_c >= CW'(T_CAS)) ? clo_c : clo_c + 1'b1);
    end
  end

  // R4
  ras_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> lo_c >= CW'(T_RAS));

  // R4
  ras_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_c >= CW'(T_RP));

  // R5
  ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (!dram_ras_n && lo_c >= CW'(T_RCD)));

  // R5
  cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> clo_c >= CW'(T_CAS));

  // R10
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_c <= CW'(T_RAS_MAX));

  // R3
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  // R3
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |=> $stable(dram_addr));

  // R2
  col_pin8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> !dram_addr[ROW_W-1]);

  // R9
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (!dram_cas_n && dram_dq_oe && dram_oe_n));

  // R8
  rsp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(dram_cas_n));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .ROW_W(ROW_W), .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD),
  .T_CAS(T_CAS), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe),
  .dram_addr(dram_addr), .rsp_valid(rsp_valid), .ref_gnt(ref_gnt),
  .req_ready(req_ready)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int B_RP = 3, B_RAS = 4, B_RCD = 2, B_CAS = 2, B_PC = 3, B_RMAX = 7500;

  // {we, expect_hit, addr[16:0], data[7:0]}; for reads data is the expected byte
  localparam logic [26:0] VEC [0:11] = '{
    {1'b1, 1'b0, 17'h00105, 8'hA5},
    {1'b1, 1'b1, 17'h00110, 8'h3C},
    {1'b0, 1'b1, 17'h00105, 8'hA5},
    {1'b0, 1'b1, 17'h00110, 8'h3C},
    {1'b1, 1'b0, 17'h1FFFF, 8'h77},
    {1'b0, 1'b1, 17'h1FF00, 8'hFF},
    {1'b0, 1'b1, 17'h1FFFF, 8'h77},
    {1'b1, 1'b0, 17'h00000, 8'h11},
    {1'b1, 1'b1, 17'h000FF, 8'h22},
    {1'b0, 1'b0, 17'h00105, 8'hA5},
    {1'b0, 1'b0, 17'h00000, 8'h11},
    {1'b0, 1'b1, 17'h000FF, 8'h22}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dq_in = '0;
  logic req_ready, rsp_valid, ref_gnt;
  logic [7:0] rsp_rdata, dq_out;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [8:0] dram_addr;

  fpm_dram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  logic [8:0] m_row = '0;

  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always @(posedge clk)
    if (!ras_n && !cas_n && !we_n) mem[int'({m_row, dram_addr[7:0]})] = dq_out;

  bit cur_we = 1'b0;
  logic [16:0] cur_addr = '0;
  logic [7:0]  cur_wdata = '0, col_seen = '0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, first_cas = 1'b1;
  int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_per = 100;
  int ras_falls = 0, cas_falls = 0, last_lo = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cas && !cas_n) begin
        chk(!ras_n, "R5 column strobe under row strobe", ras_n, 0);
        chk(ras_lo >= B_RCD, "R5 row-to-column delay", ras_lo, B_RCD);
        if (!first_cas) chk(cas_per >= B_PC, "R6 page cycle spacing", cas_per, B_PC);
        chk(dram_addr == {1'b0, cur_addr[7:0]}, "R2 column on pins", dram_addr, {1'b0, cur_addr[7:0]});
        if (cur_we)
          chk(!we_n && oe_n && dq_oe && dq_out == cur_wdata, "R9 write strobes and data",
              {we_n, oe_n, dq_oe, dq_out}, {3'b011, cur_wdata});
        else
          chk(we_n && !oe_n && !dq_oe, "R8 read strobes", {we_n, oe_n, dq_oe}, 3'b100);
        cas_falls++;
        first_cas = 1'b0;
        cas_per = 0;
        col_seen = dram_addr[7:0];
      end
      if (!prev_cas && !cas_n)
        chk(dram_addr[7:0] == col_seen, "R3 column held", dram_addr, col_seen);
      if (!prev_cas && cas_n)
        chk(cas_lo >= B_CAS, "R5 column strobe width", cas_lo, B_CAS);
      if (prev_ras && !ras_n) begin
        chk(ras_hi >= B_RP, "R4 precharge", ras_hi, B_RP);
        chk(dram_addr == cur_addr[16:8], "R2 row on pins", dram_addr, cur_addr[16:8]);
        m_row = dram_addr;
        ras_falls++;
        first_cas = 1'b1;
      end
      if (!prev_ras && !ras_n && ras_lo == 1 && cas_n)
        chk(dram_addr == m_row, "R3 row held", dram_addr, m_row);
      if (!prev_ras && ras_n) begin
        chk(ras_lo >= B_RAS, "R4 row strobe low time", ras_lo, B_RAS);
        chk(ras_lo <= B_RMAX, "R10 row strobe limit", ras_lo, B_RMAX);
        last_lo = ras_lo;
      end
      if (!ras_n) begin ras_lo = prev_ras ? 1 : ras_lo + 1; ras_hi = 0; end
      else        begin ras_hi = prev_ras ? ras_hi + 1 : 1; ras_lo = 0; end
      cas_lo  = !cas_n ? (prev_cas ? 1 : cas_lo + 1) : 0;
      cas_per = cas_per + 1;
      prev_ras = ras_n;
      prev_cas = cas_n;
      if (!ras_n && !cas_n && !oe_n) begin
        int k;
        k = int'({m_row, dram_addr[7:0]});
        dq_in = mem.exists(k) ? mem[k] : dflt({m_row, dram_addr[7:0]});
      end else dq_in = 8'h00;
    end
  end

  function automatic logic [7:0] expect_rd(input logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
  endfunction

  task automatic do_req(input bit we, input logic [16:0] a, input logic [7:0] d, input bit exp_hit);
    int rf0, cf0, n;
    bit got;
    n = 0;
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
    cur_we = we; cur_addr = a; cur_wdata = d;
    rf0 = ras_falls; cf0 = cas_falls;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!we) begin
      got = 1'b0;
      for (int i = 0; i < 60 && !got; i++) begin
        if (rsp_valid) got = 1'b1; else @(negedge clk);
      end
      chk(got, "R8 read response seen", got, 1);
      chk(rsp_rdata == expect_rd(a), "R8 read data", rsp_rdata, expect_rd(a));
      @(negedge clk);
      chk(!rsp_valid, "R8 valid lasts one cycle", rsp_valid, 0);
    end else begin
      ref_mem[int'(a)] = d;
      chk(!rsp_valid, "R9 no response on write", rsp_valid, 0);
    end
    n = 0;
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
    if (exp_hit) chk(ras_falls == rf0, "R6 page hit keeps row", ras_falls - rf0, 0);
    else         chk(ras_falls == rf0 + 1, "R7 row miss reopens", ras_falls - rf0, 1);
    chk(cas_falls == cf0 + 1, "R12 one column cycle per handshake", cas_falls - cf0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!dq_oe && !rsp_valid && !ref_gnt, "R1 outputs quiet", {dq_oe, rsp_valid, ref_gnt}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    for (int v = 0; v < 12; v++)
      do_req(VEC[v][26], VEC[v][24:8], VEC[v][7:0], VEC[v][25]);

    begin
      int n, cf0, rf0;
      bit got;
      ref_req = 1'b1;
      got = 1'b0;
      for (int i = 0; i < 40 && !got; i++) begin
        @(negedge clk);
        if (ref_gnt) got = 1'b1;
      end
      chk(got, "R11 grant raised", got, 1);
      chk(ras_n && cas_n && !req_ready, "R11 strobes released", {ras_n, cas_n, req_ready}, 3'b110);
      chk(ras_hi >= B_RP, "R11 precharge before grant", ras_hi, B_RP);
      cur_we = 1'b0; cur_addr = 17'h00105;
      cf0 = cas_falls; rf0 = ras_falls;
      req_valid = 1'b1; req_we = 1'b0; req_addr = 17'h00105;
      repeat (5) @(negedge clk);
      chk(cas_falls == cf0 && ras_n && ref_gnt, "R12 request held off during grant",
          cas_falls - cf0, 0);
      ref_req = 1'b0;
      @(negedge clk);
      chk(!ref_gnt, "R11 grant dropped", ref_gnt, 0);
      n = 0;
      while (!req_ready && n < 40) begin @(negedge clk); n++; end
      @(negedge clk);
      req_valid = 1'b0;
      got = 1'b0;
      for (int i = 0; i < 60 && !got; i++) begin
        if (rsp_valid) got = 1'b1; else @(negedge clk);
      end
      chk(got && rsp_rdata == 8'hA5, "R11 read after refresh", rsp_rdata, 8'hA5);
      chk(ras_falls == rf0 + 1, "R11 row reopened after refresh", ras_falls - rf0, 1);
      chk(cas_falls == cf0 + 1, "R12 single access after hold", cas_falls - cf0, 1);
    end

    repeat (B_RMAX + 100) @(negedge clk);
    chk(ras_n, "R10 idle row closed", ras_n, 1);
    chk(last_lo <= B_RMAX && last_lo > B_RMAX - 20, "R10 close near limit", last_lo, B_RMAX);
    do_req(1'b0, 17'h00110, 8'h3C, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule